// File: doc/BRIEF.md
# Cache Line Crossing Access Splitter

This block sits between a load/store unit and one data cache port. It takes a single access of 1, 2, 4 or 8 bytes. If a 2, 4 or 8 byte access would run past the end of a cache line, the block sends two requests to the cache, one on each side of the boundary. For a read, it joins the two returned pieces into one big-endian result. An access that stays inside one line goes to the cache unchanged, as a single request. Splitting happens only while both the data cache enable input and the split enable input are high.

Data is big-endian. The byte at the lowest address is the most significant byte of the value. Values travel right-aligned on the 64-bit data buses. The first piece starts at the original address and holds the most significant bytes. The second piece starts at the next line and holds the remaining low bytes.

The block handles one access at a time. It holds `req_ready` low from acceptance until it has returned the single response. For a write, the response is the acknowledge of the last piece.

Top module: `line_split`

## Requirements
- R1: A 1-byte access (`req_size` code 0) always goes out as exactly one cache request with length 1 at the original address.
- R2: An access whose line offset plus size is at most `LINE_BYTES` goes out as one request with length equal to the size. This includes an access that ends exactly on the last byte of a line.
- R3: When splitting is enabled, a 2, 4 or 8 byte access whose line offset plus size exceeds `LINE_BYTES` produces two requests. The first is at the original address, with length `LINE_BYTES` minus (address AND (`LINE_BYTES`-1)).
- R4: The second request of a split starts at the original address plus the first length. Its length is the access size minus the first length.
- R5: A split read returns one response. Its data is the first piece shifted left by (second length x 8) bits, ORed with the second piece, so `rsp_rdata` holds the memory bytes in big-endian order.
- R6: A split write sends the most significant first-length bytes of `req_wdata` with the first request and the low bytes with the second, so memory holds the value in big-endian order.
- R7: `cp_be` bit i is set exactly for line byte positions from the request's line offset up to offset plus `cp_len` minus 1.
- R8: When `cache_en` or `split_en` is low, a crossing access goes out as a single request with its full size at the original address.
- R9: `req_ready` is low from acceptance until the response. `rsp_valid` is a one-cycle pulse, raised only after every request of the access has been answered.
- R10: Synchronous active-low reset puts the block into idle: `req_ready` high, `cp_valid` low and `rsp_valid` low.
- R11: A crossing 2-byte access splits into two 1-byte requests.
- R12: Size codes on `req_size` are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. `cp_len` carries the byte count (1 to 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Data cache enabled |
| split_en | input | 1 | Allow line-crossing splitting |
| req_valid | input | 1 | Upstream access valid |
| req_ready | output | 1 | Block can accept an access |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code (0=1B, 1=2B, 2=4B, 3=8B) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data, right-aligned, big-endian |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Load result, right-aligned, zero above the size |
| cp_valid | output | 1 | Cache request valid |
| cp_ready | input | 1 | Cache accepts the request |
| cp_addr | output | ADDR_W | Request address |
| cp_len | output | 4 | Request length in bytes |
| cp_be | output | LINE_BYTES | Byte enables within the line |
| cp_write | output | 1 | Request is a store |
| cp_wdata | output | 64 | Request store data, right-aligned |
| cp_rvalid | input | 1 | Cache answers the oldest accepted request |
| cp_rdata | input | 64 | Returned bytes, right-aligned, big-endian |

## Verification
The hardest case to reach is a split access whose second request is stalled. The block must then hold the second address and length steady and keep `req_ready` low while the first piece is already stored internally. The bench reaches this case by dropping the cache's ready on alternate cycles during crossing reads and writes at every line offset from 9 to 15. A scoreboard compares each response with a byte-level memory model. It also checks the count, length and address of the requests issued for that access.

// File: rtl/line_split_pkg.sv
// Shared types for the line-crossing splitter.
// Assumes one access in flight at a time.
package line_split_pkg;

    // Control states of the splitter.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } split_state_t;

endpackage

// File: rtl/line_split_frag.sv
// Fragment planner: decides whether an access crosses a line boundary
// and, if so, gives the lengths of both pieces and the address of the
// second one. Purely combinational. Assumes LINE_BYTES >= MAX_BYTES.
module line_split_frag #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 8
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [$clog2(MAX_BYTES):0]        size_b,
    input  logic                              cache_en,
    input  logic                              split_en,
    output logic                              do_split,
    output logic [$clog2(MAX_BYTES):0]        len1,
    output logic [$clog2(MAX_BYTES):0]        len2,
    output logic [ADDR_W-1:0]                 addr2
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int LEN_W = $clog2(MAX_BYTES) + 1;
    localparam int SW    = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 2;

    logic [OFF_W-1:0] off;
    logic [SW-1:0]    span;
    logic [SW-1:0]    room;

    // Compute the crossing decision and piece geometry.
    always_comb begin
        off      = addr[OFF_W-1:0];
        span     = SW'(off) + SW'(size_b);
        room     = SW'(LINE_BYTES) - SW'(off);
        do_split = cache_en && split_en && (size_b > LEN_W'(1)) &&
                   (span > SW'(LINE_BYTES));
        len1     = do_split ? room[LEN_W-1:0] : size_b;
        len2     = size_b - len1;
        addr2    = addr + ADDR_W'(len1);
    end
endmodule

// File: rtl/line_split_be.sv
// Byte-enable generator: marks the line bytes covered by a request,
// given its line offset and length. Bytes beyond the line end are dropped.
module line_split_be #(
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 8
) (
    input  logic [$clog2(LINE_BYTES)-1:0] off,
    input  logic [$clog2(MAX_BYTES):0]    len,
    output logic [LINE_BYTES-1:0]         be
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int LEN_W = $clog2(MAX_BYTES) + 1;
    localparam int SW    = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 2;

    // One comparator pair per line byte.
    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_byte
        assign be[g] = (SW'(g) >= SW'(off)) && (SW'(g) < SW'(off) + SW'(len));
    end
endmodule

// File: rtl/line_split_ctrl.sv
// Sequencer: accepts one access, issues one or two cache requests,
// collects the returned pieces and merges them big-endian. Assumes the
// cache answers requests in order, one cp_rvalid per accepted request.
module line_split_ctrl
    import line_split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [$clog2(MAX_BYTES):0]    req_size_b,
    input  logic                          req_write,
    input  logic [MAX_BYTES*8-1:0]        req_wdata,
    input  logic                          plan_split,
    input  logic [$clog2(MAX_BYTES):0]    plan_len1,
    input  logic [$clog2(MAX_BYTES):0]    plan_len2,
    input  logic [ADDR_W-1:0]             plan_addr2,
    output logic                          rsp_valid,
    output logic [MAX_BYTES*8-1:0]        rsp_rdata,
    output logic                          cp_valid,
    input  logic                          cp_ready,
    output logic [ADDR_W-1:0]             cp_addr,
    output logic [$clog2(MAX_BYTES):0]    cp_len,
    output logic                          cp_write,
    output logic [MAX_BYTES*8-1:0]        cp_wdata,
    input  logic                          cp_rvalid,
    input  logic [MAX_BYTES*8-1:0]        cp_rdata
);
    localparam int LEN_W  = $clog2(MAX_BYTES) + 1;
    localparam int DATA_W = MAX_BYTES * 8;

    split_state_t            state_q;
    logic                    second_q;
    logic                    split_q;
    logic                    write_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [ADDR_W-1:0]       addr2_q;
    logic [LEN_W-1:0]        len1_q;
    logic [LEN_W-1:0]        len2_q;
    logic [DATA_W-1:0]       wdata_q;
    logic [DATA_W-1:0]       high_q;
    logic [DATA_W-1:0]       result_q;
    logic [DATA_W-1:0]       merged;

    // Keep only the n low bytes of a value.
    function automatic logic [DATA_W-1:0] keep_low(input logic [DATA_W-1:0] d,
                                                   input logic [LEN_W-1:0]  n);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int b = 0; b < MAX_BYTES; b++) begin
            if (b < int'(n)) r[b*8 +: 8] = d[b*8 +: 8];
        end
        return r;
    endfunction

    // Drive the cache request from the active piece.
    always_comb begin
        cp_valid = (state_q == ST_ISSUE);
        cp_write = write_q;
        cp_addr  = second_q ? addr2_q : addr_q;
        cp_len   = second_q ? len2_q  : len1_q;
        if (!split_q)
            cp_wdata = keep_low(wdata_q, len1_q);
        else if (second_q)
            cp_wdata = keep_low(wdata_q, len2_q);
        else
            cp_wdata = keep_low(wdata_q >> {len2_q, 3'b000}, len1_q);
    end

    // Join the stored high piece with the returning low piece.
    always_comb begin
        if (split_q)
            merged = (high_q << {len2_q, 3'b000}) | keep_low(cp_rdata, len2_q);
        else
            merged = keep_low(cp_rdata, len1_q);
    end

    // Upstream handshake outputs.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = result_q;
    end

    // State machine and capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            second_q <= 1'b0;
            split_q  <= 1'b0;
            write_q  <= 1'b0;
            addr_q   <= '0;
            addr2_q  <= '0;
            len1_q   <= '0;
            len2_q   <= '0;
            wdata_q  <= '0;
            high_q   <= '0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q  <= ST_ISSUE;
                        second_q <= 1'b0;
                        split_q  <= plan_split;
                        write_q  <= req_write;
                        addr_q   <= req_addr;
                        addr2_q  <= plan_addr2;
                        len1_q   <= plan_len1;
                        len2_q   <= plan_len2;
                        wdata_q  <= keep_low(req_wdata, req_size_b);
                    end
                end
                ST_ISSUE: begin
                    if (cp_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cp_rvalid) begin
                        if (split_q && !second_q) begin
                            high_q   <= keep_low(cp_rdata, len1_q);
                            second_q <= 1'b1;
                            state_q  <= ST_ISSUE;
                        end else begin
                            result_q <= write_q ? '0 : merged;
                            state_q  <= ST_RESP;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/line_split.sv
// Line-crossing access splitter top: decodes the size code, plans the
// pieces, sequences the cache requests and forms byte enables.
// Assumes a 2-bit size code, so MAX_BYTES is 8.
module line_split #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cache_en,
    input  logic                       split_en,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [1:0]                 req_size,
    input  logic                       req_write,
    input  logic [MAX_BYTES*8-1:0]     req_wdata,
    output logic                       rsp_valid,
    output logic [MAX_BYTES*8-1:0]     rsp_rdata,
    output logic                       cp_valid,
    input  logic                       cp_ready,
    output logic [ADDR_W-1:0]          cp_addr,
    output logic [$clog2(MAX_BYTES):0] cp_len,
    output logic [LINE_BYTES-1:0]      cp_be,
    output logic                       cp_write,
    output logic [MAX_BYTES*8-1:0]     cp_wdata,
    input  logic                       cp_rvalid,
    input  logic [MAX_BYTES*8-1:0]     cp_rdata
);
    localparam int LEN_W = $clog2(MAX_BYTES) + 1;
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [LEN_W-1:0]  size_b;
    logic              plan_split;
    logic [LEN_W-1:0]  plan_len1;
    logic [LEN_W-1:0]  plan_len2;
    logic [ADDR_W-1:0] plan_addr2;

    // Decode the size code into a byte count.
    always_comb size_b = LEN_W'(1) << req_size;

    line_split_frag #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
    ) u_frag (
        .addr(req_addr), .size_b(size_b), .cache_en(cache_en),
        .split_en(split_en), .do_split(plan_split), .len1(plan_len1),
        .len2(plan_len2), .addr2(plan_addr2)
    );

    line_split_ctrl #(
        .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size_b(size_b), .req_write(req_write),
        .req_wdata(req_wdata), .plan_split(plan_split), .plan_len1(plan_len1),
        .plan_len2(plan_len2), .plan_addr2(plan_addr2), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .cp_valid(cp_valid), .cp_ready(cp_ready),
        .cp_addr(cp_addr), .cp_len(cp_len), .cp_write(cp_write),
        .cp_wdata(cp_wdata), .cp_rvalid(cp_rvalid), .cp_rdata(cp_rdata)
    );

    line_split_be #(
        .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
    ) u_be (
        .off(cp_addr[OFF_W-1:0]), .len(cp_len), .be(cp_be)
    );
endmodule

// File: rtl/line_split_chk.sv
// Protocol checker for the splitter, attached by bind. Observes ports only.
module line_split_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_ready,
    input logic                       rsp_valid,
    input logic                       cp_valid,
    input logic                       cp_ready,
    input logic [ADDR_W-1:0]          cp_addr,
    input logic [$clog2(MAX_BYTES):0] cp_len,
    input logic [LINE_BYTES-1:0]      cp_be
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SW    = OFF_W + 6;

    logic fits;
    // Request stays inside its line.
    always_comb fits = (SW'(cp_addr[OFF_W-1:0]) + SW'(cp_len)) <= SW'(LINE_BYTES);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid |-> !req_ready);
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && !cp_ready) |=> (cp_valid && $stable(cp_addr) && $stable(cp_len)));
    p_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid |-> (cp_len >= 1 && cp_len <= MAX_BYTES));
    p_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && fits) |-> ($countones(cp_be) == int'(cp_len)));
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!cp_valid && !rsp_valid && req_ready));
endmodule

bind line_split line_split_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_addr(cp_addr),
    .cp_len(cp_len), .cp_be(cp_be)
);

// File: tb/line_split_tb.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops
// them against the design's responses and cache requests.
module line_split_tb;
    localparam int LB = 16;

    typedef struct {
        logic [31:0] addr;
        int          size;
        logic        wr;
        logic [63:0] data;
        int          nfrag;
        int          len1;
    } exp_t;

    logic        clk = 0, rst_n = 0, cache_en = 1, split_en = 1;
    logic        req_valid = 0, req_write = 0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_valid, cp_valid, cp_write;
    logic [63:0] rsp_rdata, cp_wdata;
    logic [31:0] cp_addr;
    logic [3:0]  cp_len;
    logic [15:0] cp_be;
    logic        cp_ready, cp_rvalid = 0;
    logic [63:0] cp_rdata = '0;
    logic        stall = 0, tick = 0;

    logic [7:0] cmem [256];
    logic [7:0] rmem [256];
    exp_t       q[$];
    int         n_chk = 0, n_fail = 0, cyc = 0, frag_i = 0;
    logic [31:0] first_addr;
    int          first_len;

    always #5 clk = ~clk;
    assign cp_ready = stall ? tick : 1'b1;

    line_split u_dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .split_en(split_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cp_valid(cp_valid),
        .cp_ready(cp_ready), .cp_addr(cp_addr), .cp_len(cp_len), .cp_be(cp_be),
        .cp_write(cp_write), .cp_wdata(cp_wdata), .cp_rvalid(cp_rvalid),
        .cp_rdata(cp_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Cache model: in-order, one answer the cycle after acceptance.
    always @(posedge clk) begin
        tick <= ~tick;
        if (!rst_n) cp_rvalid <= 1'b0;
        else if (cp_valid && cp_ready) begin
            logic [63:0] rd;
            rd = '0;
            for (int k = 0; k < int'(cp_len); k++) begin
                rd = (rd << 8) | 64'(cmem[8'(cp_addr + 32'(k))]);
                if (cp_write)
                    cmem[8'(cp_addr + 32'(k))] <= cp_wdata[(int'(cp_len)-1-k)*8 +: 8];
            end
            cp_rvalid <= 1'b1;
            cp_rdata  <= cp_write ? 64'd0 : rd;
        end else cp_rvalid <= 1'b0;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 100000);
            finish_test();
        end
    end

    // Monitor: request geometry and responses.
    always @(negedge clk) begin
        if (rst_n && cp_valid && cp_ready) begin
            logic [15:0] be_exp;
            int off;
            off = int'(cp_addr[3:0]);
            be_exp = '0;
            for (int i = 0; i < LB; i++)
                if (i >= off && i < off + int'(cp_len)) be_exp[i] = 1'b1;
            check(cp_be == be_exp, "R7 byte enables", 64'(cp_be), 64'(be_exp));
            check(!req_ready, "R9 ready low while busy", 64'(req_ready), 0);
            if (q.size() > 0) begin
                if (frag_i == 0) begin
                    check(cp_addr == q[0].addr, "R3 first address", 64'(cp_addr), 64'(q[0].addr));
                    check(int'(cp_len) == q[0].len1, "R3 first length", 64'(cp_len), 64'(q[0].len1));
                    first_addr = cp_addr; first_len = int'(cp_len);
                end else begin
                    check(cp_addr == first_addr + 32'(first_len), "R4 second address",
                          64'(cp_addr), 64'(first_addr + 32'(first_len)));
                    check(int'(cp_len) == q[0].size - first_len, "R4 second length",
                          64'(cp_len), 64'(q[0].size - first_len));
                end
            end
            frag_i++;
        end
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check(0, "R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(frag_i == e.nfrag, "R3 R8 fragment count", 64'(frag_i), 64'(e.nfrag));
                if (!e.wr)
                    check(rsp_rdata == e.data, "R5 read data", rsp_rdata, e.data);
            end
            frag_i = 0;
        end
    end

    // Driver: queue the expectation, then present the access.
    task automatic access(input int addr, input int code, input bit wr,
                          input logic [63:0] wd);
        exp_t e;
        int size, off;
        size = 1 << code;
        off  = addr % LB;
        e.addr = 32'(addr); e.size = size; e.wr = wr;
        e.nfrag = (cache_en && split_en && size > 1 && off + size > LB) ? 2 : 1;
        e.len1  = (e.nfrag == 2) ? LB - off : size;
        e.data  = '0;
        for (int k = 0; k < size; k++) begin
            if (wr) rmem[(addr + k) % 256] = wd[(size-1-k)*8 +: 8];
            else    e.data = (e.data << 8) | 64'(rmem[(addr + k) % 256]);
        end
        q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = 32'(addr); req_size = 2'(code);
        req_write = wr; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            cmem[i] = 8'(i * 7 + 3);
            rmem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        check(req_ready && !cp_valid && !rsp_valid, "R10 reset state",
              {61'd0, req_ready, cp_valid, rsp_valid}, 64'b100);
        rst_n = 1;
        // R1: single byte at the last line position.
        access(32'h1F, 0, 0, 0);
        // R2: fitting accesses, including one ending on the line's last byte.
        access(32'h23, 1, 0, 0);
        access(32'h2C, 2, 0, 0);
        access(32'h38, 3, 0, 0);
        // R11: 2-byte crossing access.
        access(32'h4F, 1, 0, 0);
        // R3 R4 R5: crossing reads at every offset.
        for (int o = 13; o < 16; o++) access(32'h50 + o, 2, 0, 0);
        for (int o = 9; o < 16; o++) access(32'h60 + o, 3, 0, 0);
        drain();
        // R8: splitting disabled by either enable.
        cache_en = 0; access(32'h7C, 3, 0, 0); drain();
        cache_en = 1; split_en = 0; access(32'h7D, 2, 0, 0); drain();
        split_en = 1;
        // R6: crossing writes, then readbacks.
        access(32'h8B, 3, 1, 64'h0102030405060708);
        access(32'h9E, 2, 1, 64'hA1B2C3D4);
        access(32'hAF, 1, 1, 64'hBEEF);
        access(32'h88, 3, 0, 0);
        access(32'h90, 3, 0, 0);
        access(32'h9C, 3, 0, 0);
        access(32'hAC, 3, 0, 0);
        drain();
        // Stalled cache ready during crossing traffic.
        stall = 1;
        for (int o = 9; o < 16; o++) begin
            access(32'hC0 + o, 3, 1, 64'h1122334455667788 + 64'(o));
            access(32'hC0 + o, 3, 0, 0);
        end
        access(32'hD7, 1, 0, 0);
        drain();
        stall = 0;
        finish_test();
    end
endmodule